// File: doc/BRIEF.md
# Burst Port Register Redirector

This block lives inside a timer peripheral's register file. It lets a DMA engine move a whole group of consecutive registers through one fixed bus address. Software first programs a control word with two fields: a window start and a run length. After that, every read or write of the burst data port goes to the register at window start plus a running offset. The offset steps forward after each port access. It falls back to zero once the programmed number of transfers has been made, so the next transfer opens a fresh run at the window start.

The register file here has twenty general 16-bit registers. Word indices 0 to 17 can also be reached directly, at byte address 4 × index. Word indices 18 and 19 of the direct map belong to the control word (byte 0x48) and to the burst port (byte 0x4C). General registers 18 and 19 can therefore be reached only through the burst port. A one-cycle acknowledge answers each port access that is made while the DMA request line is high.

Top module: `dma_burst_redirect`

## Requirements
- R1: After reset, the control word reads 0x0000, every general register reads 0x0000, and sel_idx is 0.
- R2: The control word sits at byte 0x48. Bits 12:8 hold the length field and bits 4:0 hold the window start. Bits 15:13 and 7:5 always read 0, so writing 0xFFFF reads back as 0x1F1F.
- R3: A write to byte 0x4C stores all 16 data bits into general register (start + offset).
- R4: The offset rises by one on each port access and clears to 0 after the access made with offset equal to the length field. The length field L therefore gives L+1 transfers per run: L=0 always hits the start register, and L=17 walks 18 registers.
- R5: A read of byte 0x4C returns general register (start + offset) and advances the offset in the same way a port write does.
- R6: Reads and writes at any address other than 0x4C and 0x48 leave the offset unchanged.
- R7: Any write to the control word clears the offset to 0.
- R8: When start + offset is 20 or more, a port write changes no register and a port read returns 0, but the offset still advances. Writes to unmapped addresses (above 0x4C) change nothing, and reads from them return 0.
- R9: rd_data takes the addressed value at the clock edge that samples rd_en, and holds it while rd_en is low.
- R10: sel_idx always shows start + offset. sel_valid is high exactly when a port access is present and start + offset is below 20.
- R11: dma_ack is high for the one cycle that follows each port access made while dma_req is high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Byte address; bits 1:0 ignored |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 16 | Write data |
| dma_req | input | 1 | DMA request from the transfer engine |
| rd_data | output | 16 | Registered read data |
| sel_idx | output | 6 | Register currently targeted by the burst port |
| sel_valid | output | 1 | A port access hits an implemented register this cycle |
| dma_ack | output | 1 | One-cycle acknowledge of a requested port access |

## Verification
sel_idx and sel_valid are combinational, so they are due in the same cycle as the access. The bench samples them before the clock edge, while the strobes are still driven. rd_data, dma_ack, register contents and the offset all change at the first rising edge after the strobe. Every bench task drives its inputs on a falling edge and samples on the next falling edge, which falls exactly one register stage later. Expected register contents come from a shadow model in the bench, which applies start + offset and the wrap rule.

// File: rtl/tdbr_pkg.sv
package tdbr_pkg;
  localparam int unsigned FLD_W = 5;
  localparam int unsigned SEL_W = FLD_W + 1;

  typedef struct packed {
    logic [FLD_W-1:0] len;
    logic [FLD_W-1:0] start;
  } ctrl_t;

  // Target register of the burst port: start plus running offset.
  function automatic logic [SEL_W-1:0] window_index(input logic [FLD_W-1:0] start,
                                                    input logic [FLD_W-1:0] ofs);
    return {1'b0, start} + {1'b0, ofs};
  endfunction

  // Read image of the control word, with zeros in the reserved bits.
  function automatic logic [15:0] ctrl_image(input ctrl_t c);
    return {3'b000, c.len, 3'b000, c.start};
  endfunction

  // Next offset after a port access.
  function automatic logic [FLD_W-1:0] next_offset(input logic [FLD_W-1:0] ofs,
                                                   input logic [FLD_W-1:0] len);
    return (ofs == len) ? '0 : ofs + 1'b1;
  endfunction
endpackage

// File: rtl/tdbr_offset.sv
module tdbr_offset
  import tdbr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [FLD_W-1:0] len,
  output logic [FLD_W-1:0] ofs
);
  always_ff @(posedge clk) begin
    if (!rst_n)     ofs <= '0;
    else if (clear) ofs <= '0;
    else if (step)  ofs <= next_offset(ofs, len);
  end
endmodule

// File: rtl/tdbr_bank.sv
module tdbr_bank #(
  parameter int unsigned NREG  = 20,
  parameter int unsigned DW    = 16,
  parameter int unsigned SEL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] widx,
  input  logic [DW-1:0]    wdata,
  input  logic [SEL_W-1:0] ridx,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                              regs[g] <= '0;
      else if (we && widx == SEL_W'(g))        regs[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (ridx == SEL_W'(i)) rdata = regs[i];
  end
endmodule

// File: rtl/dma_burst_redirect.sv
module dma_burst_redirect
  import tdbr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DW        = 16,
  parameter int unsigned NREG      = 20,
  parameter int unsigned CTRL_WORD = 18,
  parameter int unsigned PORT_WORD = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DW-1:0]     wr_data,
  input  logic              dma_req,
  output logic [DW-1:0]     rd_data,
  output logic [SEL_W-1:0]  sel_idx,
  output logic              sel_valid,
  output logic              dma_ack
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              any_acc, port_hit, ctrl_hit, direct_hit;
  logic              port_acc, ctrl_wr, in_range;
  logic [FLD_W-1:0]  ofs;
  logic [SEL_W-1:0]  win_idx, bank_idx;
  logic [DW-1:0]     bank_rdata, rd_next;
  logic              bank_we;
  ctrl_t             ctrl_q;

  assign word       = addr[ADDR_W-1:2];
  assign any_acc    = wr_en | rd_en;
  assign port_hit   = (word == WORD_W'(PORT_WORD));
  assign ctrl_hit   = (word == WORD_W'(CTRL_WORD));
  assign direct_hit = (word < WORD_W'(CTRL_WORD));
  assign port_acc   = any_acc & port_hit;
  assign ctrl_wr    = wr_en & ctrl_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= '{len: wr_data[8 +: FLD_W], start: wr_data[0 +: FLD_W]};
  end

  tdbr_offset u_ofs (
    .clk(clk), .rst_n(rst_n), .clear(ctrl_wr), .step(port_acc),
    .len(ctrl_q.len), .ofs(ofs)
  );

  assign win_idx   = window_index(ctrl_q.start, ofs);
  assign in_range  = (win_idx < SEL_W'(NREG));
  assign sel_idx   = win_idx;
  assign sel_valid = port_acc & in_range;

  assign bank_idx = port_hit ? win_idx : SEL_W'(word);
  assign bank_we  = wr_en & ((port_hit & in_range) | direct_hit);

  tdbr_bank #(.NREG(NREG), .DW(DW), .SEL_W(SEL_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(bank_we), .widx(bank_idx), .wdata(wr_data),
    .ridx(bank_idx), .rdata(bank_rdata)
  );

  always_comb begin
    if (ctrl_hit)                        rd_next = DW'(ctrl_image(ctrl_q));
    else if (port_hit)                   rd_next = in_range ? bank_rdata : '0;
    else if (direct_hit)                 rd_next = bank_rdata;
    else                                 rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      dma_ack <= 1'b0;
    end else begin
      if (rd_en) rd_data <= rd_next;
      dma_ack <= port_acc & dma_req;
    end
  end
endmodule

// File: rtl/tdbr_checker.sv
module tdbr_checker
  import tdbr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             port_acc,
  input logic             ctrl_wr,
  input logic             any_acc,
  input logic             dma_req,
  input logic             dma_ack,
  input logic             sel_valid,
  input logic [FLD_W-1:0] ofs,
  input logic [FLD_W-1:0] len
);
  assert_ofs_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ofs <= len);
  assert_ofs_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (port_acc && !ctrl_wr && ofs == len) |=> ofs == '0);
  assert_ofs_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (port_acc && ofs != len) |=> ofs == $past(ofs) + 1'b1);
  assert_ofs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_acc && !ctrl_wr) |=> $stable(ofs));
  assert_ctrl_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> ofs == '0);
  assert_sel_only_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> port_acc);
  assert_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (port_acc && dma_req) |=> dma_ack);
  assert_ack_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(port_acc && dma_req) |=> !dma_ack);
  assert_acc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    port_acc |-> any_acc);
endmodule

bind dma_burst_redirect tdbr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .port_acc(port_acc), .ctrl_wr(ctrl_wr),
  .any_acc(any_acc), .dma_req(dma_req), .dma_ack(dma_ack),
  .sel_valid(sel_valid), .ofs(ofs), .len(ctrl_q.len)
);

// File: tb/dma_burst_redirect_bench.sv
module dma_burst_redirect_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0, dma_req = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [5:0]  sel_idx;
  logic        sel_valid, dma_ack;

  int checks = 0;
  int errors = 0;
  logic [15:0] shadow [20];
  int m_start = 0, m_len = 0, m_ofs = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dma_burst_redirect u_dma_burst_redirect (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .dma_req(dma_req), .rd_data(rd_data),
    .sel_idx(sel_idx), .sel_valid(sel_valid), .dma_ack(dma_ack)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // Bench model of the port stepping rule.
  function automatic void model_step();
    m_ofs = (m_ofs == m_len) ? 0 : m_ofs + 1;
  endfunction

  task automatic bus_wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 8'h48) begin
      m_start = d[4:0]; m_len = d[12:8]; m_ofs = 0;
    end else if (a == 8'h4C) begin
      if (m_start + m_ofs < 20) shadow[m_start + m_ofs] = d;
      model_step();
    end else if (a < 8'h48) shadow[a >> 2] = d;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
    if (a == 8'h48) ;
    else if (a == 8'h4C) model_step();
  endtask

  task automatic check_all(input string tag);
    logic [15:0] d;
    for (int i = 0; i < 18; i++) begin
      bus_rd(8'(i * 4), d);
      chk(tag, d, shadow[i]);
    end
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 sel_idx after reset", sel_idx, 0);
    bus_rd(8'h48, d); chk("R1 control after reset", d, 0);
    check_all("R1 registers after reset");
  endtask

  task automatic t_ctrl_layout();
    logic [15:0] d;
    bus_wr(8'h48, 16'hFFFF);
    bus_rd(8'h48, d); chk("R2 reserved bits read zero", d, 16'h1F1F);
    chk("R10 sel_idx start+offset 31+0", sel_idx, 31);
  endtask

  task automatic t_burst_write();
    logic [15:0] d;
    bus_wr(8'h48, 16'h0203);              // start 3, length field 2
    bus_wr(8'h4C, 16'hA5C3);
    bus_wr(8'h4C, 16'h1234);
    dma_req = 1'b1;
    bus_wr(8'h4C, 16'hFFFF);
    chk("R11 ack after requested access", dma_ack, 1);
    dma_req = 1'b0;
    @(negedge clk);
    chk("R11 ack drops after one cycle", dma_ack, 0);
    chk("R4 offset wrapped, sel_idx back at start", sel_idx, 3);
    bus_wr(8'h4C, 16'h0F0F);              // lands on register 3 again
    bus_rd(8'h0C, d); chk("R3 R4 wrap rewrote register 3", d, 16'h0F0F);
    bus_rd(8'h10, d); chk("R3 full width in register 4", d, 16'h1234);
    bus_rd(8'h14, d); chk("R3 register 5", d, 16'hFFFF);
    check_all("R3 burst write image");
  endtask

  task automatic t_burst_read();
    logic [15:0] d;
    bus_wr(8'h48, 16'h0000);              // single-transfer runs at register 0
    bus_wr(8'h00, 16'h7E57);
    bus_rd(8'h4C, d); chk("R5 port read register 0", d, 16'h7E57);
    bus_rd(8'h4C, d); chk("R4 length 0 stays on register 0", d, 16'h7E57);
    bus_wr(8'h48, 16'h0103);              // start 3, two transfers
    bus_rd(8'h4C, d); chk("R5 port read register 3", d, shadow[3]);
    bus_rd(8'h4C, d); chk("R5 port read register 4", d, shadow[4]);
    @(negedge clk);
    chk("R9 rd_data held while idle", rd_data, shadow[4]);
  endtask

  task automatic t_direct_no_move();
    logic [15:0] d;
    bus_wr(8'h48, 16'h0305);              // start 5, four transfers
    bus_wr(8'h4C, 16'h0505);
    bus_wr(8'h04, 16'h0101);
    bus_rd(8'h08, d);
    chk("R6 offset kept across direct accesses", sel_idx, 6);
    bus_wr(8'h4C, 16'h0606);
    bus_rd(8'h18, d); chk("R6 next port write reached register 6", d, 16'h0606);
  endtask

  task automatic t_ctrl_clear();
    logic [15:0] d;
    bus_wr(8'h48, 16'h0402);              // start 2, five transfers
    bus_wr(8'h4C, 16'h2222);
    bus_wr(8'h4C, 16'h3333);
    bus_wr(8'h48, 16'h0402);
    chk("R7 control write clears offset", sel_idx, 2);
    bus_wr(8'h4C, 16'h2D2D);
    bus_rd(8'h08, d); chk("R7 run restarts at start register", d, 16'h2D2D);
  endtask

  task automatic t_out_of_range();
    logic [15:0] d;
    bus_wr(8'h48, 16'h0312);              // start 18, four transfers
    bus_wr(8'h4C, 16'h1818);
    bus_wr(8'h4C, 16'h1919);
    @(negedge clk);
    addr = 8'h4C; wr_data = 16'hDEAD; wr_en = 1'b1;
    #1;
    chk("R10 sel_idx 20 out of range", sel_idx, 20);
    chk("R10 sel_valid low past the file", sel_valid, 0);
    @(negedge clk);
    wr_en = 1'b0; model_step();
    bus_wr(8'h4C, 16'hBEEF);              // index 21, ignored
    bus_rd(8'h4C, d); chk("R3 burst-only register 18", d, 16'h1818);
    @(negedge clk);
    addr = 8'h4C; rd_en = 1'b1;
    #1;
    chk("R10 sel_valid high in range", sel_valid, 1);
    @(negedge clk);
    rd_en = 1'b0; model_step();
    chk("R5 burst-only register 19", rd_data, 16'h1919);
    bus_rd(8'h4C, d); chk("R8 read past file returns 0", d, 0);
    bus_rd(8'h4C, d); chk("R8 read past file returns 0 again", d, 0);
    bus_wr(8'h50, 16'h9999);
    bus_rd(8'h50, d); chk("R8 unmapped read returns 0", d, 0);
    check_all("R8 no register changed");
  endtask

  task automatic t_max_len();
    logic [15:0] d;
    bus_wr(8'h48, 16'h1100);              // start 0, eighteen transfers
    for (int i = 0; i < 18; i++) bus_wr(8'h4C, 16'(16'h0100 + i));
    chk("R4 eighteen transfers then wrap", sel_idx, 0);
    bus_wr(8'h4C, 16'hCAFE);
    bus_rd(8'h00, d); chk("R4 nineteenth write back at register 0", d, 16'hCAFE);
    check_all("R4 full run image");
  endtask

  initial begin
    for (int i = 0; i < 20; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl_layout();
    t_burst_write();
    t_burst_read();
    t_direct_no_move();
    t_ctrl_clear();
    t_out_of_range();
    t_max_len();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule